// File: doc/BRIEF.md
# Shared-Memory Ring Buffer Accessor

This block moves single bytes through byte ring buffers that live in the memory of another processor. It has no storage for the ring data. Every ring access goes through a byte-wide master port, and that port is used only after the block has taken ownership of the remote bus through a request/grant handshake. Ownership is handed back once each short sequence of accesses is finished. For every channel the block keeps a small local descriptor: the ring base address, the size mask, and cached copies of the producer and consumer indices.

A host sends a command on a ready/valid interface. Each command names an operation and a channel. The operations are: attach a ring, attach and discard pending data, test empty, test full, pop a byte, and push a byte. When the command is finished the block gives a one-cycle done pulse, with the popped byte or the result flag. Pop and push wait for the ring to become usable by polling the far-side index repeatedly. Each poll runs in its own ownership window, so the other processor can make progress between polls.

Top module: `shfifo_accessor`

## Requirements
- R1: The ring header sits at the base address. The mask byte is at base+0, the producer index at base+1 and the consumer index at base+2. Data slot i is at base+3+i. All addresses wrap modulo 2^20.
- R2: Command code 0 (attach) stores cmd_addr_i as the channel base. In one ownership window it then reads the mask, producer and consumer bytes into the descriptor.
- R3: Command code 1 (empty test) reads the producer byte from memory. It returns done_flag_o=1 exactly when that byte equals the cached consumer index.
- R4: Command code 2 (full test) reads the consumer byte from memory. It returns done_flag_o=1 exactly when (cached producer index + 1) AND mask equals that byte.
- R5: If the channel base is zero, empty and full tests return flag 1, and pop and push finish with flag 1. None of these four makes any bus request or memory access.
- R6: Command code 3 (pop) polls while the ring is empty. In one later window it reads the data slot at the cached consumer index and writes the advanced consumer index to base+2. It returns the byte on done_data_o with flag 0.
- R7: Command code 4 (push) polls while the ring is full. In one later window it writes cmd_data_i to the slot at the cached producer index and writes the advanced producer index to base+1. It finishes with flag 0.
- R8: An index advances as (index + 1) AND mask, so it wraps from mask to 0.
- R9: Command code 5 (discard) attaches like code 0. It then writes the producer byte it read into base+2, and both cached indices take that value.
- R10: mem_valid_o is high only while bus_req_o and bus_gnt_i are both high. After a window, bus_req_o stays low until bus_gnt_i has been seen low.
- R11: A memory access keeps mem_valid_o, mem_we_o, mem_addr_o and mem_wdata_o unchanged until mem_ack_i.
- R12: After reset cmd_ready_o is 1 and bus_req_o, mem_valid_o and done_o are 0. cmd_ready_o is 0 while the bus is requested. done_o is a single-cycle pulse that comes after ownership is released.
- R13: Each channel has its own descriptor. Commands on one channel leave the other channel's base, mask and indices unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle and accepting |
| cmd_op_i | input | 3 | Operation code (0 attach, 1 empty, 2 full, 3 pop, 4 push, 5 discard) |
| cmd_chan_i | input | CH_W | Channel select |
| cmd_addr_i | input | 20 | Ring base for attach/discard |
| cmd_data_i | input | 8 | Byte to push |
| done_o | output | 1 | Command finished (one cycle) |
| done_data_o | output | 8 | Popped byte |
| done_flag_o | output | 1 | Empty/full result, or 1 for an unattached pop/push |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus ownership granted |
| mem_valid_o | output | 1 | Memory access pending |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 20 | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_ack_i | input | 1 | Access completed |
| mem_rdata_i | input | 8 | Read byte, valid with ack |

## Verification
The assertions check the bus protocol on every cycle. Accesses happen only under grant, a request is never reissued before the grant falls, access fields stay stable until acknowledge, and done is a single pulse that cannot overlap a request. Only the bench scenarios can show the ring behaviour itself: addresses, masked wrap, the data order through push and pop, a pop held off until a producer outside the block writes, the discard copy, and the fact that the two channels do not disturb each other.

// File: rtl/shfifo_pkg.sv
package shfifo_pkg;
  parameter int ADDR_W = 20;
  parameter int DATA_W = 8;

  localparam int OFS_MASK = 0;
  localparam int OFS_IN   = 1;
  localparam int OFS_OUT  = 2;
  localparam int OFS_DATA = 3;

  typedef enum logic [2:0] {
    OP_INIT  = 3'd0,
    OP_EMPTY = 3'd1,
    OP_FULL  = 3'd2,
    OP_GET   = 3'd3,
    OP_PUT   = 3'd4,
    OP_MSG   = 3'd5
  } op_e;

  typedef enum logic [2:0] {S_IDLE, S_ACQ, S_ACC, S_WAIT, S_REL, S_FIN} st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] in_idx;
    logic [DATA_W-1:0] out_idx;
  } desc_t;

  // field write enables
  localparam int WE_BASE = 3;
  localparam int WE_MASK = 2;
  localparam int WE_IN   = 1;
  localparam int WE_OUT  = 0;
endpackage

// File: rtl/shfifo_desc.sv
module shfifo_desc import shfifo_pkg::*; #(
  parameter int N_CH = 2,
  parameter int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_W-1:0] ch_i,
  input  logic [3:0]      we_i,
  input  desc_t           wr_i,
  output desc_t           rd_o
);
  desc_t regs [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs[c] <= '0;
      end else if (ch_i == CH_W'(c)) begin
        if (we_i[WE_BASE]) regs[c].base    <= wr_i.base;
        if (we_i[WE_MASK]) regs[c].mask    <= wr_i.mask;
        if (we_i[WE_IN])   regs[c].in_idx  <= wr_i.in_idx;
        if (we_i[WE_OUT])  regs[c].out_idx <= wr_i.out_idx;
      end
    end
  end

  always_comb begin
    rd_o = '0;
    for (int c = 0; c < N_CH; c++)
      if (ch_i == CH_W'(c)) rd_o = regs[c];
  end
endmodule

// File: rtl/shfifo_mport.sv
module shfifo_mport import shfifo_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_valid_o <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      done_o <= mem_valid_o && mem_ack_i;
      if (start_i) begin
        mem_valid_o <= 1'b1;
        mem_we_o    <= we_i;
        mem_addr_o  <= addr_i;
        mem_wdata_o <= wdata_i;
      end else if (mem_valid_o && mem_ack_i) begin
        mem_valid_o <= 1'b0;
        rdata_o     <= mem_rdata_i;
      end
    end
  end
endmodule

// File: rtl/shfifo_accessor.sv
module shfifo_accessor import shfifo_pkg::*; #(
  parameter int N_CH = 2,
  parameter int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [CH_W-1:0]   cmd_chan_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              done_o,
  output logic [DATA_W-1:0] done_data_o,
  output logic              done_flag_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  st_e               state_q;
  op_e               op_q, cop;
  logic [CH_W-1:0]   ch_q, sel_ch;
  logic [DATA_W-1:0] pdata_q, tmp_q, res_data_q;
  logic              res_flag_q, phase_q, cond_q;
  logic [1:0]        step_q;

  desc_t             d, dw;
  logic [3:0]        dw_en;
  logic              pdone, acc_start, acc_we, acc_last;
  logic [DATA_W-1:0] prd, acc_wd, nxt_in, nxt_out;
  logic [ADDR_W-1:0] off;

  assign cop       = op_e'(cmd_op_i);
  assign sel_ch    = (state_q == S_IDLE) ? cmd_chan_i : ch_q;
  assign nxt_in    = (d.in_idx + 1'b1) & d.mask;
  assign nxt_out   = (d.out_idx + 1'b1) & d.mask;
  assign acc_start = (state_q == S_ACC);

  shfifo_desc #(.N_CH(N_CH), .CH_W(CH_W)) u_desc (
    .clk_i, .rst_ni, .ch_i(sel_ch), .we_i(dw_en), .wr_i(dw), .rd_o(d)
  );

  shfifo_mport u_mport (
    .clk_i, .rst_ni, .start_i(acc_start), .we_i(acc_we),
    .addr_i(d.base + off), .wdata_i(acc_wd), .done_o(pdone), .rdata_o(prd),
    .mem_valid_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  // access selected by operation, phase (0 = poll, 1 = transfer) and step
  always_comb begin
    off = '0; acc_we = 1'b0; acc_wd = '0; acc_last = 1'b0;
    case (op_q)
      OP_INIT:  begin off = ADDR_W'(step_q); acc_last = (step_q == 2'd2); end
      OP_EMPTY: begin off = ADDR_W'(OFS_IN);  acc_last = 1'b1; end
      OP_FULL:  begin off = ADDR_W'(OFS_OUT); acc_last = 1'b1; end
      OP_GET:
        if (!phase_q) begin off = ADDR_W'(OFS_IN); acc_last = 1'b1; end
        else if (step_q == 2'd0) off = ADDR_W'(OFS_DATA) + ADDR_W'(d.out_idx);
        else begin off = ADDR_W'(OFS_OUT); acc_we = 1'b1; acc_wd = nxt_out; acc_last = 1'b1; end
      OP_PUT:
        if (!phase_q) begin off = ADDR_W'(OFS_OUT); acc_last = 1'b1; end
        else if (step_q == 2'd0) begin
          off = ADDR_W'(OFS_DATA) + ADDR_W'(d.in_idx); acc_we = 1'b1; acc_wd = pdata_q;
        end else begin off = ADDR_W'(OFS_IN); acc_we = 1'b1; acc_wd = nxt_in; acc_last = 1'b1; end
      OP_MSG: begin
        off = ADDR_W'(step_q);
        if (step_q == 2'd2) begin acc_we = 1'b1; acc_wd = tmp_q; acc_last = 1'b1; end
      end
      default: acc_last = 1'b1;
    endcase
  end

  // descriptor updates
  always_comb begin
    dw_en = '0;
    dw    = d;
    if (state_q == S_IDLE && cmd_valid_i && (cop == OP_INIT || cop == OP_MSG)) begin
      dw_en[WE_BASE] = 1'b1;
      dw.base        = cmd_addr_i;
    end else if (state_q == S_WAIT && pdone) begin
      case (op_q)
        OP_INIT: begin
          dw.mask = prd; dw.in_idx = prd; dw.out_idx = prd;
          dw_en[WE_MASK] = (step_q == 2'd0);
          dw_en[WE_IN]   = (step_q == 2'd1);
          dw_en[WE_OUT]  = (step_q == 2'd2);
        end
        OP_GET: begin dw.out_idx = nxt_out; dw_en[WE_OUT] = phase_q && step_q == 2'd1; end
        OP_PUT: begin dw.in_idx  = nxt_in;  dw_en[WE_IN]  = phase_q && step_q == 2'd1; end
        OP_MSG: begin
          dw.mask = prd; dw.in_idx = tmp_q; dw.out_idx = tmp_q;
          dw_en[WE_MASK] = (step_q == 2'd0);
          dw_en[WE_IN]   = (step_q == 2'd2);
          dw_en[WE_OUT]  = (step_q == 2'd2);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; op_q <= OP_INIT; ch_q <= '0; pdata_q <= '0;
      tmp_q <= '0; res_data_q <= '0; res_flag_q <= 1'b0;
      phase_q <= 1'b0; cond_q <= 1'b0; step_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          op_q <= cop; ch_q <= cmd_chan_i; pdata_q <= cmd_data_i;
          phase_q <= 1'b0; step_q <= '0; res_data_q <= '0; res_flag_q <= 1'b0;
          case (cop)
            OP_INIT, OP_MSG: state_q <= S_ACQ;
            OP_EMPTY, OP_FULL, OP_GET, OP_PUT:
              if (d.base == '0) begin res_flag_q <= 1'b1; state_q <= S_FIN; end
              else state_q <= S_ACQ;
            default: state_q <= S_FIN;
          endcase
        end
        S_ACQ:  if (bus_gnt_i) state_q <= S_ACC;
        S_ACC:  state_q <= S_WAIT;
        S_WAIT: if (pdone) begin
          case (op_q)
            OP_EMPTY: res_flag_q <= (prd == d.out_idx);
            OP_FULL:  res_flag_q <= (nxt_in == prd);
            OP_GET: begin
              if (!phase_q) cond_q <= (prd == d.out_idx);
              else if (step_q == 2'd0) res_data_q <= prd;
            end
            OP_PUT:  if (!phase_q) cond_q <= (nxt_in == prd);
            OP_MSG:  if (step_q == 2'd1) tmp_q <= prd;
            default: ;
          endcase
          if (acc_last) state_q <= S_REL;
          else begin step_q <= step_q + 1'b1; state_q <= S_ACC; end
        end
        S_REL: if (!bus_gnt_i) begin
          step_q <= '0;
          if ((op_q == OP_GET || op_q == OP_PUT) && !phase_q) begin
            phase_q <= !cond_q;
            state_q <= S_ACQ;
          end else state_q <= S_FIN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == S_IDLE);
  assign bus_req_o   = (state_q == S_ACQ) || (state_q == S_ACC) || (state_q == S_WAIT);
  assign done_o      = (state_q == S_FIN);
  assign done_data_o = res_data_q;
  assign done_flag_o = res_flag_q;
endmodule

// File: rtl/shfifo_chk.sv
module shfifo_chk import shfifo_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_ready_o,
  input logic              done_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              mem_valid_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i
);
  // R10
  access_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> bus_req_o && bus_gnt_i);

  // R10
  rerequest_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_o && bus_gnt_i) |=> !bus_req_o);

  // R11
  access_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ack_i) |=> mem_valid_o && $stable(mem_we_o)
      && $stable(mem_addr_o) && $stable(mem_wdata_o));

  // R12
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !cmd_ready_o);

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R12
  done_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o && !mem_valid_o);
endmodule

bind shfifo_accessor shfifo_chk u_chk (
  .clk_i, .rst_ni, .cmd_ready_o, .done_o, .bus_req_o, .bus_gnt_i,
  .mem_valid_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i
);

// File: tb/shfifo_accessor_tb_top.sv
module shfifo_accessor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [0:0]  cmd_chan = '0;
  logic [19:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        done, done_flag;
  logic [7:0]  done_data;
  logic        bus_req, bus_gnt;
  logic        mem_valid, mem_we, mem_ack;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  shfifo_accessor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_chan_i(cmd_chan), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .done_o(done), .done_data_o(done_data), .done_flag_o(done_flag),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  logic [7:0] mem [logic [19:0]];
  int n_tests = 0, n_fail = 0, n_acc = 0, n_viol = 0, cyc = 0;
  time t_done, t_prod;

  function automatic logic [7:0] rdm(input logic [19:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] adv(input logic [7:0] i, input logic [7:0] m);
    return (i + 8'd1) & m;
  endfunction
  function automatic logic [19:0] slot(input logic [19:0] b, input logic [7:0] i);
    return b + 20'd3 + 20'(i);
  endfunction

  // arbiter and memory responder
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_gnt <= 1'b0; mem_ack <= 1'b0; mem_rdata <= '0;
    end else begin
      if (bus_req != bus_gnt && $urandom_range(0, 2) == 0) bus_gnt <= bus_req;
      mem_ack <= 1'b0;
      if (mem_valid && !mem_ack && $urandom_range(0, 1) == 0) begin
        mem_ack <= 1'b1;
        n_acc++;
        if (!(bus_req && bus_gnt)) n_viol++;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata <= rdm(mem_addr);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic ch, input logic [19:0] a,
                        input logic [7:0] dat, output logic [7:0] rd, output logic fl);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_chan = ch; cmd_addr = a; cmd_data = dat;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    rd = done_data; fl = done_flag; t_done = $time;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  localparam logic [19:0] B0 = 20'h0FF00;
  localparam logic [19:0] B1 = 20'hFFFFE;

  initial begin
    logic [7:0] rd, m_in, m_out, m_mask, v, exp_q[$];
    logic fl;
    int a0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 ready", {31'd0, cmd_ready}, 1);
    check("R12 idle", {29'd0, bus_req, mem_valid, done}, 0);
    rst_n = 1'b1;

    // R5 unattached channels: no bus activity
    a0 = n_acc;
    do_cmd(3'd1, 1'b0, '0, '0, rd, fl); check("R5 empty flag", {31'd0, fl}, 1);
    do_cmd(3'd4, 1'b1, '0, 8'h11, rd, fl); check("R5 put flag", {31'd0, fl}, 1);
    do_cmd(3'd3, 1'b0, '0, '0, rd, fl); check("R5 get flag", {31'd0, fl}, 1);
    check("R5 no access", n_acc - a0, 0);
    @(negedge clk); check("R12 done pulse", {31'd0, done}, 0);

    // R2 attach ch0: mask 7, indices 3
    m_mask = 8'h07; m_in = 8'h03; m_out = 8'h03;
    mem[B0] = m_mask; mem[B0 + 1] = m_in; mem[B0 + 2] = m_out;
    do_cmd(3'd0, 1'b0, B0, '0, rd, fl);
    do_cmd(3'd1, 1'b0, '0, '0, rd, fl); check("R2 R3 empty after attach", {31'd0, fl}, 1);
    do_cmd(3'd2, 1'b0, '0, '0, rd, fl); check("R4 not full", {31'd0, fl}, 0);

    // R7 R8 fill with wrap
    for (int k = 0; k < 7; k++) begin
      v = 8'($urandom);
      do_cmd(3'd4, 1'b0, '0, v, rd, fl);
      check("R7 put flag", {31'd0, fl}, 0);
      check("R1 R7 slot", {24'd0, rdm(slot(B0, m_in))}, {24'd0, v});
      exp_q.push_back(v);
      m_in = adv(m_in, m_mask);
      check("R8 in index", {24'd0, rdm(B0 + 1)}, {24'd0, m_in});
    end
    do_cmd(3'd2, 1'b0, '0, '0, rd, fl); check("R4 full", {31'd0, fl}, 1);
    do_cmd(3'd1, 1'b0, '0, '0, rd, fl); check("R3 not empty", {31'd0, fl}, 0);

    // R6 drain
    for (int k = 0; k < 7; k++) begin
      do_cmd(3'd3, 1'b0, '0, '0, rd, fl);
      check("R6 get data", {24'd0, rd}, {24'd0, exp_q.pop_front()});
      check("R6 get flag", {31'd0, fl}, 0);
      m_out = adv(m_out, m_mask);
      check("R8 out index", {24'd0, rdm(B0 + 2)}, {24'd0, m_out});
    end

    // R9 discard on ch1, header wrapping past the top of the address space
    mem[B1] = 8'h03; mem[20'(B1 + 1)] = 8'h02; mem[20'(B1 + 2)] = 8'h00;
    do_cmd(3'd5, 1'b1, B1, '0, rd, fl);
    check("R9 out copied", {24'd0, rdm(20'(B1 + 2))}, 32'h02);
    do_cmd(3'd1, 1'b1, '0, '0, rd, fl); check("R9 empty after discard", {31'd0, fl}, 1);

    // R6 pop blocks until a far-side producer writes
    fork
      do_cmd(3'd3, 1'b1, '0, '0, rd, fl);
      begin
        repeat (300) @(negedge clk);
        mem[slot(B1, 8'h02)] = 8'hA5; mem[20'(B1 + 1)] = 8'h03; t_prod = $time;
      end
    join
    check("R6 waited", {31'd0, t_done > t_prod}, 1);
    check("R1 R6 wrapped slot data", {24'd0, rd}, 32'hA5);
    check("R6 out written", {24'd0, rdm(20'(B1 + 2))}, 32'h03);

    // R13 ch0 untouched by ch1 traffic
    do_cmd(3'd1, 1'b0, '0, '0, rd, fl); check("R13 ch0 empty", {31'd0, fl}, 1);

    // random mix on ch0, checked against the index model
    for (int k = 0; k < 300; k++) begin
      int sel = $urandom_range(0, 3);
      logic chn = 1'b0;
      if (sel == 0 && adv(m_in, m_mask) != m_out) begin
        v = 8'($urandom);
        do_cmd(3'd4, chn, '0, v, rd, fl);
        exp_q.push_back(v); m_in = adv(m_in, m_mask);
        check("R7 rand in", {24'd0, rdm(B0 + 1)}, {24'd0, m_in});
      end else if (sel == 1 && m_in != m_out) begin
        do_cmd(3'd3, chn, '0, '0, rd, fl);
        check("R6 rand data", {24'd0, rd}, {24'd0, exp_q.pop_front()});
        m_out = adv(m_out, m_mask);
      end else if (sel == 2) begin
        do_cmd(3'd1, chn, '0, '0, rd, fl);
        check("R3 rand empty", {31'd0, fl}, {31'd0, m_in == m_out});
      end else begin
        do_cmd(3'd2, chn, '0, '0, rd, fl);
        check("R4 rand full", {31'd0, fl}, {31'd0, adv(m_in, m_mask) == m_out});
      end
    end
    do_cmd(3'd1, 1'b1, '0, '0, rd, fl); check("R13 ch1 empty", {31'd0, fl}, 1);
    check("R10 ownership", n_viol, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule